// File: doc/BRIEF.md
# Memory Barrier Sequencer

This block orders memory traffic around two barrier instructions. It keeps a count of the explicit memory transactions that the load/store pipeline has issued but that have not yet completed. When a barrier is accepted while that count is nonzero, the block asserts a stall until the count drains to zero. It then pulses a done flag for one cycle and releases the stall.

There are two barrier kinds. A synchronization barrier holds back every later instruction, so both stalls are raised. A memory barrier holds back only later memory transactions, so only the memory stall is raised and other instructions keep flowing. Both barriers are write-only and are accepted from User and privileged code in either security state. A read access to a barrier encoding is flagged as undefined and starts nothing.

The memory stall also gates the issue pulse inside the block. While the memory stall is high, the count can only fall. A request that arrives while a barrier is active is held in a one-entry slot and is launched after the active barrier finishes.

Top module: `mbar_seq`

## Requirements
- R1: During and straight after reset, `ins_stall`, `mem_stall`, `bar_done`, `bar_undef` and `cnt_err` are all 0, and the outstanding count is 0.
- R2: The outstanding count rises by one for each counted `txn_issue` pulse and falls by one for each `txn_done` pulse. A cycle that has both a counted issue and a completion leaves the count unchanged.
- R3: A write request of kind synchronization (`bar_kind`=0) that leaves a nonzero count raises both `ins_stall` and `mem_stall` from the next cycle. Both stay high until the barrier completes.
- R4: A write request of kind memory (`bar_kind`=1) that leaves a nonzero count raises `mem_stall` from the next cycle, and `ins_stall` stays 0.
- R5: An active barrier completes in the cycle after the cycle in which the count reaches zero. In that cycle `bar_done` is 1 for exactly one cycle and both stalls are 0.
- R6: If the count after the request cycle's own update is zero, `bar_done` is 1 in the next cycle and no stall is raised.
- R7: While `mem_stall` is 1, `txn_issue` is not counted.
- R8: A request with `bar_rd`=1 raises `bar_undef` for one cycle in the next cycle. It starts no barrier: no stall and no done follow from it.
- R9: With the default parameter `USER_OK`=1, `bar_user` has no effect: a User-mode write request behaves exactly like a privileged one.
- R10: A write request that arrives while a barrier is active is held. It is treated as a fresh request in the cycle after the active barrier's done. A further request that arrives while the slot is already occupied merges into it, and the merged barrier is a synchronization barrier if either of the two was.
- R11: A `txn_done` pulse that arrives when the count is zero and no issue is counted leaves the count at zero and sets `cnt_err`. `cnt_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bar_req | input | 1 | One-cycle barrier access pulse |
| bar_kind | input | 1 | 0 = synchronization barrier, 1 = memory barrier |
| bar_rd | input | 1 | 1 = the access is a read (undefined) |
| bar_user | input | 1 | 1 = the access comes from User mode |
| txn_issue | input | 1 | An explicit memory transaction is issued this cycle |
| txn_done | input | 1 | An explicit memory transaction completed this cycle |
| ins_stall | output | 1 | Hold all instruction issue |
| mem_stall | output | 1 | Hold memory-transaction issue (gates `txn_issue`) |
| bar_done | output | 1 | One-cycle pulse: a barrier has completed |
| bar_undef | output | 1 | One-cycle pulse: undefined barrier access |
| cnt_err | output | 1 | Sticky flag: a completion arrived with the count at zero |

## Verification
Every output is a register, so each result is due one cycle after the cycle whose inputs cause it. `bar_done` and the released stalls appear one cycle after the count reaches zero. `bar_undef` appears one cycle after the read request. A held request completes one cycle after the done of the barrier ahead of it. The bench drives inputs just after the rising edge and samples all outputs at the falling edge of the same cycle in which its model predicts them. It compares every output in every cycle against a model that is updated at the same edge as the design, and it adds directed checks with fixed expected values at these delays.

// File: rtl/mbar_pkg.sv
`timescale 1ns/1ps
package mbar_pkg;

    typedef enum logic {
        BAR_SYNC = 1'b0,
        BAR_MEM  = 1'b1
    } bar_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } seq_st_e;

    typedef struct packed {
        seq_st_e   st;
        bar_kind_e kind;
        logic      held_v;
        bar_kind_e held_kind;
        logic      done;
        logic      undef;
        logic      ins_stall;
        logic      mem_stall;
    } seq_t;

    // the stronger of two barriers: synchronization covers a memory barrier
    function automatic bar_kind_e kind_merge(bar_kind_e a, bar_kind_e b);
        return (a == BAR_SYNC || b == BAR_SYNC) ? BAR_SYNC : BAR_MEM;
    endfunction

endpackage

// File: rtl/mbar_txn_cnt.sv
`timescale 1ns/1ps
module mbar_txn_cnt #(
    parameter int CW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic gate,
    input  logic cmpl,
    output logic zero_nxt,
    output logic err
);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          err;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic issue_ok;

    always_comb begin
        cnt_d    = cnt_q;
        issue_ok = issue & ~gate;
        unique case ({issue_ok, cmpl})
            2'b10: cnt_d.cnt = cnt_q.cnt + CNT_ONE;
            2'b01: begin
                if (cnt_q.cnt == '0) cnt_d.err = 1'b1;
                else                 cnt_d.cnt = cnt_q.cnt - CNT_ONE;
            end
            default: ;
        endcase
        zero_nxt = (cnt_d.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign err = cnt_q.err;

endmodule

// File: rtl/mbar_req_dec.sv
`timescale 1ns/1ps
module mbar_req_dec #(
    parameter bit USER_OK = 1'b1
) (
    input  logic req,
    input  logic rd,
    input  logic user,
    output logic acc,
    output logic undef
);
    logic denied;

    always_comb begin
        denied = rd | (user & ~USER_OK);
        acc    = req & ~denied;
        undef  = req & denied;
    end

endmodule

// File: rtl/mbar_seq_ctl.sv
`timescale 1ns/1ps
module mbar_seq_ctl
    import mbar_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      acc,
    input  bar_kind_e acc_kind,
    input  logic      undef_in,
    input  logic      zero_nxt,
    output logic      ins_stall,
    output logic      mem_stall,
    output logic      done,
    output logic      undef
);
    seq_t s_d, s_q;
    logic      take;
    bar_kind_e take_kind;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.undef = undef_in;
        take      = 1'b0;
        take_kind = acc_kind;

        if (s_q.st == ST_IDLE) begin
            if (s_q.held_v) begin
                take          = 1'b1;
                take_kind     = s_q.held_kind;
                s_d.held_v    = acc;
                s_d.held_kind = acc_kind;
            end else if (acc) begin
                take = 1'b1;
            end
            if (take) begin
                if (zero_nxt) begin
                    s_d.done = 1'b1;
                end else begin
                    s_d.st   = ST_WAIT;
                    s_d.kind = take_kind;
                end
            end
        end else begin
            if (acc) begin
                s_d.held_v    = 1'b1;
                s_d.held_kind = s_q.held_v ? kind_merge(s_q.held_kind, acc_kind)
                                           : acc_kind;
            end
            if (zero_nxt) begin
                s_d.st   = ST_IDLE;
                s_d.done = 1'b1;
            end
        end

        s_d.mem_stall = (s_d.st == ST_WAIT);
        s_d.ins_stall = (s_d.st == ST_WAIT) && (s_d.kind == BAR_SYNC);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ins_stall = s_q.ins_stall;
    assign mem_stall = s_q.mem_stall;
    assign done      = s_q.done;
    assign undef     = s_q.undef;

endmodule

// File: rtl/mbar_seq.sv
`timescale 1ns/1ps
module mbar_seq
    import mbar_pkg::*;
#(
    parameter int CW      = 4,
    parameter bit USER_OK = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bar_req,
    input  logic bar_kind,
    input  logic bar_rd,
    input  logic bar_user,
    input  logic txn_issue,
    input  logic txn_done,
    output logic ins_stall,
    output logic mem_stall,
    output logic bar_done,
    output logic bar_undef,
    output logic cnt_err
);
    logic acc, undef_c, zero_nxt;

    mbar_req_dec #(.USER_OK(USER_OK)) u_dec (
        .req   (bar_req),
        .rd    (bar_rd),
        .user  (bar_user),
        .acc   (acc),
        .undef (undef_c)
    );

    mbar_txn_cnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (txn_issue),
        .gate     (mem_stall),
        .cmpl     (txn_done),
        .zero_nxt (zero_nxt),
        .err      (cnt_err)
    );

    mbar_seq_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .acc_kind  (bar_kind_e'(bar_kind)),
        .undef_in  (undef_c),
        .zero_nxt  (zero_nxt),
        .ins_stall (ins_stall),
        .mem_stall (mem_stall),
        .done      (bar_done),
        .undef     (bar_undef)
    );

endmodule

// File: rtl/mbar_seq_chk.sv
`timescale 1ns/1ps
module mbar_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic bar_req,
    input logic bar_kind,
    input logic bar_rd,
    input logic bar_user,
    input logic txn_issue,
    input logic txn_done,
    input logic ins_stall,
    input logic mem_stall,
    input logic bar_done,
    input logic bar_undef,
    input logic cnt_err
);
    // R8
    undef_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_req && bar_rd) |=> bar_undef);

    // R4
    stall_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_stall |-> mem_stall);

    // R5
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bar_done |-> (!mem_stall && !ins_stall));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stall |=> (mem_stall || bar_done));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_err |=> cnt_err);

endmodule

bind mbar_seq mbar_seq_chk u_chk (.*);

// File: tb/sim_mbar_seq.sv
`timescale 1ns/1ps
module sim_mbar_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bar_req = 0, bar_kind = 0, bar_rd = 0, bar_user = 0;
    logic txn_issue = 0, txn_done = 0;
    logic ins_stall, mem_stall, bar_done, bar_undef, cnt_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mbar_seq u0 (.*);

    // bench model of the requirements, advanced at each rising edge
    int m_cnt;
    bit m_err, m_act, m_kind, m_hv, m_hk, m_done, m_undef, m_ins, m_mem;

    always @(posedge clk) begin
        int nc;
        bit iss, acc, ndone, nact, nk, nhv, nhk, take, tk;
        if (!rst_n) begin
            m_cnt = 0; m_err = 0; m_act = 0; m_kind = 0; m_hv = 0; m_hk = 0;
            m_done = 0; m_undef = 0; m_ins = 0; m_mem = 0;
        end else begin
            iss = txn_issue && !m_mem;                            // R7
            nc  = m_cnt + (iss ? 1 : 0) - (txn_done ? 1 : 0);     // R2
            if (nc < 0) begin nc = 0; m_err = 1; end              // R11
            acc = bar_req && !bar_rd;                             // R9
            ndone = 0; nact = m_act; nk = m_kind; nhv = m_hv; nhk = m_hk;
            take = 0; tk = bar_kind;
            if (!m_act) begin
                if (m_hv) begin take = 1; tk = m_hk; nhv = acc; nhk = bar_kind; end
                else if (acc) take = 1;
                if (take) begin
                    if (nc == 0) ndone = 1;
                    else begin nact = 1; nk = tk; end
                end
            end else begin
                if (acc) begin
                    nhk = m_hv ? ((m_hk == 0 || bar_kind == 0) ? 1'b0 : 1'b1) : bar_kind;
                    nhv = 1;
                end
                if (nc == 0) begin nact = 0; ndone = 1; end
            end
            m_act = nact; m_kind = nk; m_hv = nhv; m_hk = nhk; m_done = ndone;
            m_undef = bar_req && bar_rd;
            m_mem = nact; m_ins = nact && (nk == 0);
            m_cnt = nc;
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // every cycle: all outputs against the model, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 ins_stall", ins_stall, m_ins);
            chk("R4/R7 mem_stall", mem_stall, m_mem);
            chk("R5 bar_done", bar_done, m_done);
            chk("R8 bar_undef", bar_undef, m_undef);
            chk("R11 cnt_err", cnt_err, m_err);
        end
    end

    // one cycle of stimulus, held from just after one edge to just after the next
    task automatic cyc(bit req, bit kind, bit rd, bit user, bit iss, bit dn);
        @(posedge clk); #1;
        bar_req = req; bar_kind = kind; bar_rd = rd; bar_user = user;
        txn_issue = iss; txn_done = dn;
        @(posedge clk); #1;
        bar_req = 0; bar_kind = 0; bar_rd = 0; bar_user = 0;
        txn_issue = 0; txn_done = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 ins_stall", ins_stall, 0);
        chk("R1 mem_stall", mem_stall, 0);
        chk("R1 bar_done", bar_done, 0);
        chk("R1 bar_undef", bar_undef, 0);
        chk("R1 cnt_err", cnt_err, 0);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk("R1 after release mem_stall", mem_stall, 0);

        // R6: zero count, immediate completion
        cyc(1, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R6 done", bar_done, 1);
        chk("R6 no stall", mem_stall, 0);

        // R3: sync barrier over three transactions
        repeat (3) cyc(0, 0, 0, 0, 1, 0);
        cyc(1, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R3 ins_stall up", ins_stall, 1);
        chk("R3 mem_stall up", mem_stall, 1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R3 stall held", ins_stall, 1);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1);
        @(negedge clk);
        chk("R3 still stalled", ins_stall, 1);
        cyc(0, 0, 0, 0, 0, 1);
        @(negedge clk);
        chk("R5 done", bar_done, 1);
        chk("R5 ins released", ins_stall, 0);
        chk("R5 mem released", mem_stall, 0);
        @(negedge clk);
        chk("R5 done one cycle", bar_done, 0);

        // R4 / R7: memory barrier, issue during stall is ignored
        repeat (2) cyc(0, 0, 0, 0, 1, 0);
        cyc(1, 1, 0, 0, 0, 0);
        @(negedge clk);
        chk("R4 mem_stall", mem_stall, 1);
        chk("R4 ins free", ins_stall, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1);
        @(negedge clk);
        chk("R7 done despite gated issue", bar_done, 1);

        // R2: simultaneous issue and completion keeps the count
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 1, 1);
        cyc(1, 1, 0, 0, 0, 0);
        @(negedge clk);
        chk("R2 count still one", mem_stall, 1);
        cyc(0, 0, 0, 0, 0, 1);
        @(negedge clk);
        chk("R2 drained", bar_done, 1);

        // R8: read access
        cyc(1, 0, 1, 0, 0, 0);
        @(negedge clk);
        chk("R8 undef", bar_undef, 1);
        chk("R8 no done", bar_done, 0);
        chk("R8 no stall", mem_stall, 0);

        // R9: User mode accepted
        cyc(1, 0, 0, 1, 0, 0);
        @(negedge clk);
        chk("R9 user done", bar_done, 1);
        chk("R9 user no undef", bar_undef, 0);

        // R10: held and merged requests
        cyc(0, 0, 0, 0, 1, 0);
        cyc(1, 1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        @(negedge clk);
        chk("R10 active is memory", ins_stall, 0);
        chk("R10 active stall", mem_stall, 1);
        cyc(0, 0, 0, 0, 0, 1);
        @(negedge clk);
        chk("R10 first done", bar_done, 1);
        @(negedge clk);
        chk("R10 merged done", bar_done, 1);
        @(negedge clk);
        chk("R10 only one merged", bar_done, 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            bar_req   = ($urandom_range(0, 7) == 0);
            bar_kind  = $urandom_range(0, 1);
            bar_rd    = bar_req && ($urandom_range(0, 5) == 0);
            bar_user  = $urandom_range(0, 1);
            txn_issue = (m_cnt < 12) && ($urandom_range(0, 9) < 4);
            txn_done  = (m_cnt > 0) && ($urandom_range(0, 19) < 9);
        end
        @(posedge clk); #1;
        bar_req = 0; bar_rd = 0; bar_user = 0; txn_issue = 0; txn_done = 0;
        for (int i = 0; i < 100 && (m_cnt > 0 || m_act || m_hv); i++) begin
            txn_done = (m_cnt > 0);
            @(posedge clk); #1;
            txn_done = 0;
        end
        repeat (3) @(posedge clk);

        // R11: completion at zero count
        @(negedge clk);
        chk("R11 clean before", cnt_err, 0);
        cyc(0, 0, 0, 0, 0, 1);
        @(negedge clk);
        chk("R11 err set", cnt_err, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 err sticky", cnt_err, 1);

        finished = 1;
        summary();
        $finish;
    end
endmodule